// File: doc/BRIEF.md
# In-Band Addressed Transmit Write Decoder

This block sits on the physical-layer side of a link-to-PHY transmit bus and turns the bus cycles into writes for a set of per-port transmit buffers. Every rising clock edge it samples the bus: an active-low write enable, a data word, an address marker, start-of-packet, end-of-packet, a two-bit byte modulo, an abort flag and an odd parity bit. A cycle with the enable inactive and the marker high is an address cycle: the low byte of the data word names the port that all following data writes go to. A cycle with the enable active is a data cycle. The block turns it into a one-cycle, one-hot write strobe for the selected port, together with the data word, a count of valid bytes and the packet flags.

The block also applies two checks. Odd parity is checked on data and address cycles; a mismatch is reported, and the data still goes through unchanged. Each port has an almost-full input. While that input is high, only a programmable number of further writes to the port are accepted. Any write beyond that number is dropped and reported, until the port's almost-full input falls again. The abort, parity and overflow reports are single-cycle pulses and carry the number of the port concerned. A build parameter gives a single-port variant, in which the address marker is ignored and the port stays at 0.

Top module: `txw_decoder`

## Requirements
- R1: A cycle with `wr_en_n` high and `addr_mark` high loads `din[7:0]` into the selected port, shown on `cur_port` after that edge. Bits above 7 of `din` are ignored, so ports 0 to 255 can be named.
- R2: While `wr_en_n` is low, `addr_mark` is ignored and the selected port is kept. While `wr_en_n` is high, `sop`, `eop`, `mod`, `err` and `din` produce no write and no abort.
- R3: Every data cycle writes to the most recently addressed port. After the edge, the registered `wr_stb` has exactly the bit of that port set for one cycle. A selected port numbered `PORTS` or above produces no strobe.
- R4: For an accepted write, `wr_data` carries `din` unchanged, and `wr_sop` and `wr_eop` carry the flags. On a 32-bit bus, `wr_nbytes` is 4 when `eop` is low. When `eop` is high it is 4 minus `mod`: codes 0, 1, 2 and 3 give 4, 3, 2 and 1 bytes, counted from bit 31 downward.
- R5: An accepted write with both `err` and `eop` high sets `wr_abort` with its strobe and pulses `abort_evt` for one cycle. `err` without `eop` has no effect.
- R6: Parity is odd, so the count of ones over `din` and `par` must be odd. It is checked on data cycles and on address cycles only. A mismatch pulses `perr_evt` for one cycle, and the written data is unchanged.
- R7: While `port_afull[p]` is high, at most `allow_lim` writes to port p are accepted. Each further write is dropped and pulses `ovf_evt`. The count restarts from zero at every edge where `port_afull[p]` is low.
- R8: With `SINGLE` set, `addr_mark` is ignored. The port is fixed at 0, every data cycle writes to port 0, and address cycles are not parity checked.
- R9: After reset, no strobe is set, `cur_port` is 0 and no event pulse is high.
- R10: Whenever `abort_evt`, `perr_evt` or `ovf_evt` is high, `evt_port` names the port concerned. On an address cycle this is the newly addressed port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write enable |
| addr_mark | input | 1 | Address cycle marker, used while `wr_en_n` is high |
| din | input | DATA_W | Data word, or port number in bits 7:0 |
| par | input | 1 | Odd parity over `din` |
| sop | input | 1 | First word of a packet |
| eop | input | 1 | Last word of a packet |
| mod | input | 2 | Byte modulo of the last word |
| err | input | 1 | Abort flag, used with `eop` |
| port_afull | input | PORTS | Per-port almost-full status |
| allow_lim | input | LIM_W | Writes allowed after almost-full rises |
| wr_stb | output | PORTS | One-hot per-port write strobe |
| wr_data | output | DATA_W | Data of the write |
| wr_nbytes | output | 3 | Valid byte count of the write |
| wr_sop | output | 1 | Start-of-packet of the write |
| wr_eop | output | 1 | End-of-packet of the write |
| wr_abort | output | 1 | Packet aborted with this write |
| cur_port | output | 8 | Currently selected port |
| perr_evt | output | 1 | Parity error pulse |
| ovf_evt | output | 1 | Dropped-write pulse |
| abort_evt | output | 1 | Abort pulse |
| evt_port | output | 8 | Port of the pulsed event |

## Verification
Every result is due exactly one edge after the cycle that causes it: strobes, write fields, event pulses, `evt_port` and the new `cur_port` all come from one register stage. The bench therefore drives a cycle, waits for the next rising edge, and compares the outputs one time unit later, before it drives the next cycle. Its model of the selected port and the per-port allowance counters is stepped at that same edge, so each compare uses the state that edge produces. The sweep covers every modulo code, every port, ports out of range and allowance limits 0 to 3.

// File: rtl/txw_pkg.sv
package txw_pkg;
   localparam int PORT_NUM_W = 8;
   typedef logic [PORT_NUM_W-1:0] port_t;

   // valid bytes in the last word of a 32-bit bus
   function automatic logic [2:0] last_word_bytes(input logic [1:0] m);
      return 3'd4 - {1'b0, m};
   endfunction
endpackage

// File: rtl/txw_port_sel.sv
module txw_port_sel
   import txw_pkg::*;
#(
   parameter bit SINGLE = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  addr_cyc,
   input  logic  data_cyc,
   input  port_t addr_in,
   output port_t sel,
   output port_t sel_nxt
);
   generate
      if (SINGLE) begin : g_fixed
         assign sel     = '0;
         assign sel_nxt = '0;
      end else begin : g_inband
         port_t sel_q;
         assign sel_nxt = addr_cyc ? addr_in : sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q <= '0;
            else        sel_q <= sel_nxt;
         end
         assign sel = sel_q;

         // R2: the port cannot change on a data cycle
         a_r2_port_kept: assert property (@(posedge clk) disable iff (!rst_n)
            data_cyc |=> $stable(sel_q));
      end
   endgenerate
endmodule

// File: rtl/txw_par_chk.sv
module txw_par_chk #(
   parameter int W = 32
) (
   input  logic         chk_en,
   input  logic [W-1:0] d,
   input  logic         p,
   output logic         bad
);
   // odd parity: data plus parity bit must hold an odd count of ones
   assign bad = chk_en && !(^{d, p});
endmodule

// File: rtl/txw_allow_ctr.sv
module txw_allow_ctr #(
   parameter int LIM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             afull,
   input  logic             wr_hit,
   input  logic [LIM_W-1:0] lim,
   output logic             accept,
   output logic             reject
);
   logic [LIM_W-1:0] used_q;

   assign accept = wr_hit && (!afull || (used_q < lim));
   assign reject = wr_hit && !accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              used_q <= '0;
      else if (!afull)         used_q <= '0;
      else if (accept)         used_q <= used_q + 1'b1;
   end

   // R7: a dropped write is only possible while almost-full is high
   a_r7_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> afull);
   // R7: the count restarts after the status falls
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !afull |=> (used_q == '0));
endmodule

// File: rtl/txw_decoder.sv
module txw_decoder
   import txw_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PORTS  = 4,
   parameter int LIM_W  = 4,
   parameter bit SINGLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_n,
   input  logic              addr_mark,
   input  logic [DATA_W-1:0] din,
   input  logic              par,
   input  logic              sop,
   input  logic              eop,
   input  logic [1:0]        mod,
   input  logic              err,
   input  logic [PORTS-1:0]  port_afull,
   input  logic [LIM_W-1:0]  allow_lim,
   output logic [PORTS-1:0]  wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic [2:0]        wr_nbytes,
   output logic              wr_sop,
   output logic              wr_eop,
   output logic              wr_abort,
   output logic [7:0]        cur_port,
   output logic              perr_evt,
   output logic              ovf_evt,
   output logic              abort_evt,
   output logic [7:0]        evt_port
);
   localparam int MAX_PORTS = 1 << PORT_NUM_W;

   // elaboration checks
   generate
      if (!(DATA_W == 8 || DATA_W == 32)) begin : g_bad_width
         $error("txw_decoder: DATA_W must be 8 or 32");
      end
      if (PORTS < 1 || PORTS > MAX_PORTS) begin : g_bad_ports
         $error("txw_decoder: PORTS out of range");
      end
      if (LIM_W < 1 || LIM_W > 16) begin : g_bad_lim
         $error("txw_decoder: LIM_W out of range");
      end
   endgenerate

   logic       data_cyc, addr_cyc, par_bad;
   port_t      sel, sel_nxt;
   logic [PORTS-1:0] hit, acc, rej;
   logic       acc_any, rej_any;
   logic [2:0] nbytes;

   assign data_cyc = !wr_en_n;
   assign addr_cyc = wr_en_n && addr_mark && !SINGLE;

   txw_port_sel #(.SINGLE(SINGLE)) u_sel (
      .clk(clk), .rst_n(rst_n), .addr_cyc(addr_cyc), .data_cyc(data_cyc),
      .addr_in(din[7:0]), .sel(sel), .sel_nxt(sel_nxt)
   );

   txw_par_chk #(.W(DATA_W)) u_par (
      .chk_en(data_cyc || addr_cyc), .d(din), .p(par), .bad(par_bad)
   );

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         assign hit[p] = data_cyc && (sel == PORT_NUM_W'(p));
         txw_allow_ctr #(.LIM_W(LIM_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .afull(port_afull[p]), .wr_hit(hit[p]),
            .lim(allow_lim), .accept(acc[p]), .reject(rej[p])
         );
      end

      if (DATA_W == 32) begin : g_wide
         assign nbytes = eop ? last_word_bytes(mod) : 3'd4;
      end else begin : g_narrow
         assign nbytes = 3'd1;
      end
   endgenerate

   assign acc_any = |acc;
   assign rej_any = |rej;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb    <= '0;
         wr_data   <= '0;
         wr_nbytes <= '0;
         wr_sop    <= 1'b0;
         wr_eop    <= 1'b0;
         wr_abort  <= 1'b0;
         perr_evt  <= 1'b0;
         ovf_evt   <= 1'b0;
         abort_evt <= 1'b0;
         evt_port  <= '0;
      end else begin
         wr_stb    <= acc;
         if (acc_any) begin
            wr_data   <= din;
            wr_nbytes <= nbytes;
         end
         wr_sop    <= acc_any && sop;
         wr_eop    <= acc_any && eop;
         wr_abort  <= acc_any && eop && err;
         abort_evt <= acc_any && eop && err;
         perr_evt  <= par_bad;
         ovf_evt   <= rej_any;
         evt_port  <= sel_nxt;
      end
   end

   assign cur_port = sel;

   // R3: at most one port is written per cycle
   a_r3_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb));
   // R3: a strobe follows a data cycle
   a_r3_stb_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb) |-> $past(!wr_en_n));
   // R5: an abort only comes with the last word of a written packet
   a_r5_abort_with_eop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_abort |-> (wr_eop && (|wr_stb)));
   // R6: parity errors only come from data or address cycles
   a_r6_perr_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      perr_evt |-> $past(!wr_en_n || addr_mark));
   // R7: drops only while some port is almost full
   a_r7_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |-> $past(|port_afull));
   // R7: a dropped write never strobes
   a_r7_no_stb_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |-> (wr_stb == '0));
endmodule

// File: tb/sim_txw_decoder.sv
module sim_txw_decoder;
   localparam int NP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        wr_en_n = 1'b1, addr_mark = 1'b0, par = 1'b0;
   logic        sop = 1'b0, eop = 1'b0, err = 1'b0;
   logic [1:0]  mod = 2'd0;
   logic [31:0] din = '0;
   logic [NP-1:0] afull = '0;
   logic [3:0]  lim = 4'd2;

   logic [NP-1:0] o_stb;
   logic [31:0] o_data;
   logic [2:0]  o_nb;
   logic        o_sop, o_eop, o_abort, o_perr, o_ovf, o_aevt;
   logic [7:0]  o_cur, o_evtp;

   logic [0:0]  s_stb;
   logic [31:0] s_data;
   logic [2:0]  s_nb;
   logic        s_sop, s_eop, s_abort, s_perr, s_ovf, s_aevt;
   logic [7:0]  s_cur, s_evtp;

   txw_decoder #(.DATA_W(32), .PORTS(NP), .LIM_W(4), .SINGLE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .addr_mark(addr_mark), .din(din),
      .par(par), .sop(sop), .eop(eop), .mod(mod), .err(err), .port_afull(afull),
      .allow_lim(lim), .wr_stb(o_stb), .wr_data(o_data), .wr_nbytes(o_nb),
      .wr_sop(o_sop), .wr_eop(o_eop), .wr_abort(o_abort), .cur_port(o_cur),
      .perr_evt(o_perr), .ovf_evt(o_ovf), .abort_evt(o_aevt), .evt_port(o_evtp));

   txw_decoder #(.DATA_W(32), .PORTS(1), .LIM_W(4), .SINGLE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .addr_mark(addr_mark), .din(din),
      .par(par), .sop(sop), .eop(eop), .mod(mod), .err(err), .port_afull(1'b0),
      .allow_lim(lim), .wr_stb(s_stb), .wr_data(s_data), .wr_nbytes(s_nb),
      .wr_sop(s_sop), .wr_eop(s_eop), .wr_abort(s_abort), .cur_port(s_cur),
      .perr_evt(s_perr), .ovf_evt(s_ovf), .abort_evt(s_aevt), .evt_port(s_evtp));

   int nchk = 0, nerr = 0;
   int m_sel = 0;
   int m_cnt [NP];
   bit done = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // step the allowance model at an edge; acc_p = accepted port or -1
   task automatic model_edge(input int acc_p);
      for (int q = 0; q < NP; q++) begin
         if (!afull[q]) m_cnt[q] = 0;
         else if (q == acc_p) m_cnt[q]++;
      end
   endtask

   task automatic do_write(input logic [31:0] d, input logic s, input logic e,
                           input logic [1:0] m, input logic er, input logic bad,
                           input logic mark);
      int p;
      bit acc, rej;
      wr_en_n = 1'b0; addr_mark = mark; din = d; sop = s; eop = e; mod = m; err = er;
      par = (~^d) ^ bad;
      p   = m_sel;
      acc = (p < NP) && (!afull[p] || (m_cnt[p] < int'(lim)));
      rej = (p < NP) && !acc;
      @(posedge clk); #1;
      model_edge(acc ? p : -1);
      chk("R3 write strobe", 64'(o_stb), acc ? 64'(1 << p) : 64'd0);
      chk("R7 overflow pulse", 64'(o_ovf), 64'(rej));
      chk("R2 port kept on data cycle", 64'(o_cur), 64'(p));
      chk("R6 parity pulse", 64'(o_perr), 64'(bad));
      if (acc) begin
         chk("R4 data", 64'(o_data), 64'(d));
         chk("R4 byte count", 64'(o_nb), e ? 64'(4 - int'(m)) : 64'd4);
         chk("R4 sop flag", 64'(o_sop), 64'(s));
         chk("R4 eop flag", 64'(o_eop), 64'(e));
         chk("R5 abort flag", 64'(o_abort), 64'(e && er));
         chk("R5 abort pulse", 64'(o_aevt), 64'(e && er));
      end else begin
         chk("R5 no abort on drop", 64'(o_aevt), 64'd0);
      end
      if (bad || rej || (acc && e && er))
         chk("R10 event port", 64'(o_evtp), 64'(p));
      chk("R8 single-port strobe", 64'(s_stb), 64'd1);
      chk("R8 single-port port", 64'(s_cur), 64'd0);
      chk("R8 single-port parity", 64'(s_perr), 64'(bad));
   endtask

   task automatic do_addr(input logic [7:0] a, input logic [23:0] hi, input logic bad);
      wr_en_n = 1'b1; addr_mark = 1'b1; din = {hi, a}; sop = 1'b1; eop = 1'b1; err = 1'b1;
      mod = 2'd3;
      par = (~^{hi, a}) ^ bad;
      @(posedge clk); #1;
      model_edge(-1);
      m_sel = int'(a);
      chk("R1 port loaded", 64'(o_cur), 64'(a));
      chk("R3 no strobe on address", 64'(o_stb), 64'd0);
      chk("R6 address parity", 64'(o_perr), 64'(bad));
      if (bad) chk("R10 address event port", 64'(o_evtp), 64'(a));
      chk("R8 single ignores address", 64'(s_cur), 64'd0);
      chk("R8 single no address parity", 64'(s_perr), 64'd0);
      chk("R8 single no strobe", 64'(s_stb), 64'd0);
   endtask

   task automatic do_idle(input logic [31:0] d);
      wr_en_n = 1'b1; addr_mark = 1'b0; din = d; sop = 1'b1; eop = 1'b1; err = 1'b1;
      par = ^d;  // deliberately wrong parity
      @(posedge clk); #1;
      model_edge(-1);
      chk("R2 idle no strobe", 64'(o_stb), 64'd0);
      chk("R2 idle no abort", 64'(o_aevt), 64'd0);
      chk("R6 idle not checked", 64'(o_perr), 64'd0);
      chk("R2 idle port kept", 64'(o_cur), 64'(m_sel));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         nerr++;
         $display("FAIL R3 watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin
      for (int q = 0; q < NP; q++) m_cnt[q] = 0;
      #35;
      chk("R9 reset strobe", 64'(o_stb), 64'd0);
      chk("R9 reset port", 64'(o_cur), 64'd0);
      chk("R9 reset events", 64'({o_perr, o_ovf, o_aevt}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after release", 64'({o_stb, o_perr, o_ovf, o_aevt}), 64'd0);

      // address with junk upper bits, modulo sweep
      do_addr(8'd2, 24'hABCDEF, 1'b0);
      for (int m = 0; m < 4; m++)
         do_write(32'h1122_3344 + 32'(m) * 32'h0101_0101, (m == 0), 1'b1, 2'(m), 1'b0, 1'b0, 1'b0);
      do_write(32'hDEAD_BEEF, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      do_write(32'h0000_0003, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1); // marker ignored
      do_idle(32'h0000_0001);
      // abort with and without end of packet
      do_write(32'hCAFE_0001, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
      do_write(32'hCAFE_0002, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
      // parity errors on data and address cycles
      do_write(32'h5A5A_A5A5, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
      do_addr(8'd1, 24'h123456, 1'b1);
      do_write(32'h7777_0000, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0);

      // every port
      for (int p = 0; p < NP; p++) begin
         do_addr(8'(p), 24'(p * 7919), 1'b0);
         for (int k = 0; k < 4; k++)
            do_write(32'(p * 65536 + k * 4099), (k == 0), (k == 3), 2'(k), 1'b0, 1'b0, 1'b0);
      end
      // port beyond PORTS
      do_addr(8'd200, 24'h0, 1'b0);
      do_write(32'h0BAD_0BAD, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);

      // allowance sweep
      for (int l = 0; l < 4; l++) begin
         lim = 4'(l);
         for (int p = 0; p < NP; p++) begin
            do_addr(8'(p), 24'hFFFFFF, 1'b0);
            afull[p] = 1'b1;
            afull[(p + 1) % NP] = 1'b1;
            for (int k = 0; k < l + 2; k++)
               do_write(32'(l * 256 + p * 16 + k), 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
            do_write(32'hEEEE_0000, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
            afull = '0;
            do_write(32'hF00D_0000 + 32'(p), 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule